// File: doc/BRIEF.md
# Ethernet Receive Packet Queue

This block sits between a receive MAC byte stream and a host register interface. Incoming frames arrive one byte per cycle, marked with start and end flags. Each accepted frame goes into its own fixed-size slot of a circular store. The slot holds a little-endian 16-bit length header, then the frame bytes, then a CRC-32 computed over those bytes, then zero fill up to the next 32-bit boundary. The host drains packets through one data register, one 32-bit word per read, and the queue moves to the next slot on its own once a packet's last word has been read.

The host also has a pending-packet count register, a raw status bit that is set for every stored frame, an interrupt mask and a control register. The control register holds a receive enable bit and a self-clearing flush command. The interrupt request is the status bit gated by the mask. After a frame's end byte, the block takes a few cycles to write the trailer and header. During that time it holds its byte input not ready.

Top module: `eth_rx_pktq`

## Requirements
- R1: A frame whose start byte arrives while the enable bit (control bit 0) is clear is consumed and discarded. The pending count and the status register stay unchanged.
- R2: At most NUM_SLOTS (31) packets are pending. A frame that starts while the queue is full is consumed and dropped, and the count stays at NUM_SLOTS. rx_ready_o stays high while the queue is full.
- R3: Stored bytes 0 and 1 of a packet hold the frame byte count plus 6, low byte first.
- R4: After the frame bytes come the four bytes of the standard CRC-32 of the frame (reflected polynomial 0xEDB88320, initial value all ones, final inversion), least significant byte first.
- R5: The bytes that follow the CRC up to the next 32-bit boundary read as zero.
- R6: A data read (word address 3) of a pending packet returns the next four stored bytes, the earliest byte in bits 7:0. After the word that reaches the stored length, the next read starts the following packet, in arrival order and across the slot wrap, and the count drops by one.
- R7: A data read while no packet is pending returns zero and changes neither the count nor the next packet delivered.
- R8: Writing control bit 1 as one clears the pending count, abandons a partly read packet and aborts a frame being stored. The next frame stored is then read from its header.
- R9: Storing a frame sets status bit 0. Writing a one to status bit 0 clears it. irq_o equals status bit 0 AND mask bit 0, and the mask resets to one.
- R10: A frame longer than SLOT_BYTES-6 bytes (58 by default) is dropped entirely. A frame of exactly that length is stored.
- R11: The word addresses are 0 status, 1 mask, 2 control, 4 pending count. Read data appears on reg_rdata_o in the cycle after the read strobe. After reset, status, control and count read as zero and the mask reads as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sop_i | input | 1 | Byte is the first of a frame |
| rx_eop_i | input | 1 | Byte is the last of a frame |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Byte accepted on this edge when high |
| reg_rd_i | input | 1 | Host read strobe |
| reg_wr_i | input | 1 | Host write strobe |
| reg_addr_i | input | 3 | Host word address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data, one cycle after the strobe |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A wrong read offset or a wrong slot pointer shows up on the very next data read. It appears as a header word that does not match the expected length, or as bytes from another packet. A pending count that drifts from the real number of stored packets appears at once in the count register. It also shows later as a zero word where packet data was due, or as a frame dropped before 31 are pending. A wrong CRC state or a wrong pad position is caught on the final word of that packet. Each of these is therefore seen within one packet's worth of reads after the fault.

// File: rtl/eth_rx_pktq_pkg.sv
package eth_rx_pktq_pkg;

  localparam logic [2:0] ADDR_STATUS = 3'd0;
  localparam logic [2:0] ADDR_MASK   = 3'd1;
  localparam logic [2:0] ADDR_CTRL   = 3'd2;
  localparam logic [2:0] ADDR_DATA   = 3'd3;
  localparam logic [2:0] ADDR_COUNT  = 3'd4;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FLUSH_BIT = 1;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_BODY,
    WR_DROP,
    WR_TAIL
  } wr_state_e;

  typedef enum logic [1:0] {
    TL_CRC,
    TL_PAD,
    TL_LEN0,
    TL_LEN1
  } tail_ph_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_rx_pktq_store.sv
module eth_rx_pktq_store #(
  parameter int DEPTH = 1984,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // four byte taps form one little-endian word
  for (genvar k = 0; k < 4; k++) begin : g_tap
    assign rdata_o[8*k +: 8] = mem_q[raddr_i + AW'(k)];
  end

endmodule

// File: rtl/eth_rx_pktq_writer.sv
module eth_rx_pktq_writer
  import eth_rx_pktq_pkg::*;
#(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 64,
  localparam int SW   = $clog2(NUM_SLOTS),
  localparam int OW   = $clog2(SLOT_BYTES),
  localparam int AW   = $clog2(NUM_SLOTS * SLOT_BYTES),
  localparam int MAXF = SLOT_BYTES - 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic          rx_sop_i,
  input  logic          rx_eop_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  input  logic          enable_i,
  input  logic          full_i,
  input  logic          flush_i,
  input  logic [SW-1:0] slot_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic          commit_o
);

  wr_state_e   st_q, st_d;
  tail_ph_e    ph_q, ph_d;
  logic [SW-1:0] slot_q, slot_d, wslot;
  logic [OW:0]   pos_q, pos_d, woff;
  logic [OW:0]   nb_q, nb_d;
  logic [31:0]   crc_q, crc_d, crc_fin;
  logic [1:0]    k_q, k_d;
  logic [15:0]   len16;
  logic          take;

  assign rx_ready_o = (st_q != WR_TAIL);
  assign take       = rx_valid_i && rx_ready_o;
  assign crc_fin    = ~crc_q;
  assign len16      = 16'(nb_q) + 16'd6;
  assign waddr_o    = AW'(wslot) * AW'(SLOT_BYTES) + AW'(woff);

  always_comb begin
    st_d = st_q; ph_d = ph_q; slot_d = slot_q; pos_d = pos_q;
    nb_d = nb_q; crc_d = crc_q; k_d = k_q;
    we_o = 1'b0; wslot = slot_q; woff = pos_q; wdata_o = rx_data_i; commit_o = 1'b0;
    if (flush_i) begin
      st_d = WR_IDLE;
    end else if (st_q == WR_TAIL) begin
      unique case (ph_q)
        TL_CRC: begin
          we_o = 1'b1;
          wdata_o = crc_fin[{k_q, 3'b000} +: 8];
          pos_d = pos_q + 1'b1;
          k_d = k_q + 1'b1;
          if (k_q == 2'd3) ph_d = TL_PAD;
        end
        TL_PAD: begin
          if (pos_q[1:0] != 2'b00) begin
            we_o = 1'b1;
            wdata_o = 8'h00;
            pos_d = pos_q + 1'b1;
          end else begin
            ph_d = TL_LEN0;
          end
        end
        TL_LEN0: begin
          we_o = 1'b1;
          woff = '0;
          wdata_o = len16[7:0];
          ph_d = TL_LEN1;
        end
        default: begin
          we_o = 1'b1;
          woff = (OW+1)'(1);
          wdata_o = len16[15:8];
          commit_o = 1'b1;
          st_d = WR_IDLE;
        end
      endcase
    end else if (take) begin
      if (rx_sop_i) begin
        if (enable_i && !full_i) begin
          we_o = 1'b1;
          wslot = slot_i;
          woff = (OW+1)'(2);
          slot_d = slot_i;
          pos_d = (OW+1)'(3);
          nb_d = (OW+1)'(1);
          crc_d = crc32_step(CRC_INIT, rx_data_i);
          k_d = 2'd0;
          ph_d = TL_CRC;
          st_d = rx_eop_i ? WR_TAIL : WR_BODY;
        end else begin
          st_d = rx_eop_i ? WR_IDLE : WR_DROP;
        end
      end else if (st_q == WR_BODY) begin
        if (nb_q == (OW+1)'(MAXF)) begin
          st_d = rx_eop_i ? WR_IDLE : WR_DROP;
        end else begin
          we_o = 1'b1;
          pos_d = pos_q + 1'b1;
          nb_d = nb_q + 1'b1;
          crc_d = crc32_step(crc_q, rx_data_i);
          if (rx_eop_i) st_d = WR_TAIL;
        end
      end else if (st_q == WR_DROP && rx_eop_i) begin
        st_d = WR_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= WR_IDLE; ph_q <= TL_CRC; slot_q <= '0; pos_q <= '0;
      nb_q <= '0; crc_q <= CRC_INIT; k_q <= '0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; slot_q <= slot_d; pos_q <= pos_d;
      nb_q <= nb_d; crc_q <= crc_d; k_q <= k_d;
    end
  end

endmodule

// File: rtl/eth_rx_pktq.sv
module eth_rx_pktq
  import eth_rx_pktq_pkg::*;
#(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 64,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int OW = $clog2(SLOT_BYTES),
  localparam int CW = $clog2(NUM_SLOTS + 1),
  localparam int DEPTH = NUM_SLOTS * SLOT_BYTES,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic        rx_sop_i,
  input  logic        rx_eop_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  input  logic        reg_rd_i,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);

  logic          en_q, mask_q, ris_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] head_q, wr_slot;
  logic [OW-1:0] off_q;
  logic [15:0]   len_q, cur_len;
  logic [31:0]   rdata_q, word;
  logic [SW:0]   slot_sum;
  logic          full, flush, data_rd, pop, last, commit;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [7:0]    wdata;

  assign full     = (cnt_q == CW'(NUM_SLOTS));
  assign slot_sum = (SW+1)'(head_q) + (SW+1)'(cnt_q);
  assign wr_slot  = (slot_sum >= (SW+1)'(NUM_SLOTS)) ? SW'(slot_sum - (SW+1)'(NUM_SLOTS))
                                                    : SW'(slot_sum);
  assign flush    = reg_wr_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[CTRL_FLUSH_BIT];
  assign data_rd  = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign pop      = data_rd && (cnt_q != '0);
  assign raddr    = AW'(head_q) * AW'(SLOT_BYTES) + AW'(off_q);
  // the header sits in the first word; latch it when that word is read
  assign cur_len  = (off_q == '0) ? word[15:0] : len_q;
  assign last     = ({1'b0, 16'(off_q)} + 17'd4) >= {1'b0, cur_len};

  eth_rx_pktq_writer #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_BYTES(SLOT_BYTES)
  ) u_writer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_valid_i(rx_valid_i),
    .rx_sop_i  (rx_sop_i),
    .rx_eop_i  (rx_eop_i),
    .rx_data_i (rx_data_i),
    .rx_ready_o(rx_ready_o),
    .enable_i  (en_q),
    .full_i    (full),
    .flush_i   (flush),
    .slot_i    (wr_slot),
    .we_o      (we),
    .waddr_o   (waddr),
    .wdata_o   (wdata),
    .commit_o  (commit)
  );

  eth_rx_pktq_store #(
    .DEPTH(DEPTH)
  ) u_store (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .rdata_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; head_q <= '0; off_q <= '0; len_q <= '0;
    end else if (flush) begin
      cnt_q <= '0; off_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(commit) - CW'(pop && last);
      if (pop) begin
        if (last) begin
          off_q  <= '0;
          head_q <= (head_q == SW'(NUM_SLOTS - 1)) ? '0 : head_q + 1'b1;
        end else begin
          off_q <= off_q + OW'(4);
          if (off_q == '0) len_q <= cur_len;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; mask_q <= 1'b1; ris_q <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == ADDR_CTRL) en_q <= reg_wdata_i[CTRL_EN_BIT];
      if (reg_wr_i && reg_addr_i == ADDR_MASK) mask_q <= reg_wdata_i[0];
      if (commit) ris_q <= 1'b1;
      else if (reg_wr_i && reg_addr_i == ADDR_STATUS && reg_wdata_i[0]) ris_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      unique case (reg_addr_i)
        ADDR_STATUS: rdata_q <= {31'd0, ris_q};
        ADDR_MASK:   rdata_q <= {31'd0, mask_q};
        ADDR_CTRL:   rdata_q <= {31'd0, en_q};
        ADDR_DATA:   rdata_q <= pop ? word : 32'd0;
        ADDR_COUNT:  rdata_q <= 32'(cnt_q);
        default:     rdata_q <= 32'd0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = ris_q & mask_q;

endmodule

// File: rtl/eth_rx_pktq_chk.sv
module eth_rx_pktq_chk
  import eth_rx_pktq_pkg::*;
#(
  parameter int NUM_SLOTS = 31,
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_rd_i,
  input logic          reg_wr_i,
  input logic [2:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic [31:0]   reg_rdata_o,
  input logic [CW-1:0] cnt_i,
  input logic          commit_i,
  input logic          ris_i
);

  logic flush_w;
  assign flush_w = reg_wr_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[CTRL_FLUSH_BIT];

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_i) <= NUM_SLOTS);  // R2

  AST_COMMIT_SETS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> ris_i);  // R9

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_DATA && cnt_i == '0 && !commit_i && !reg_wr_i)
      |=> (reg_rdata_o == 32'd0) && (cnt_i == $past(cnt_i)));  // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w |=> (cnt_i == '0));  // R8

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_w |=> ((int'(cnt_i) - int'($past(cnt_i)) <= 1) &&
                  (int'($past(cnt_i)) - int'(cnt_i) <= 1)));  // R6

endmodule

bind eth_rx_pktq eth_rx_pktq_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .CW       (CW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_rd_i   (reg_rd_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .cnt_i      (cnt_q),
  .commit_i   (commit),
  .ris_i      (ris_q)
);

// File: tb/tb_eth_rx_pktq.sv
`timescale 1ns/1ps
module tb_eth_rx_pktq;

  localparam int NSLOT = 31;
  localparam int MAXF  = 58;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready_o;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] exp_dat [64][64];
  int         exp_len [64];
  int         mh = 0, mc = 0;

  always #2.5 clk = ~clk;

  eth_rx_pktq dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid), .rx_sop_i(rx_sop), .rx_eop_i(rx_eop), .rx_data_i(rx_data),
    .rx_ready_o(rx_ready_o),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    v = reg_rdata_o;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic send_frame(input int n, input bit keep);
    logic [7:0] fb [128];
    int slot;
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!rx_ready_o) @(negedge clk);
      rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == n - 1); rx_data = fb[i];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    repeat (12) @(negedge clk);
    if (keep) begin
      slot = (mh + mc) % 64;
      exp_len[slot] = n;
      for (int i = 0; i < n; i++) exp_dat[slot][i] = fb[i];
      mc++;
    end
  endtask

  function automatic logic [31:0] crc_ref(input int slot);
    logic [31:0] c;
    logic fbit;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < exp_len[slot]; i++) begin
      for (int b = 0; b < 8; b++) begin
        fbit = c[0] ^ exp_dat[slot][i][b];
        c = {1'b0, c[31:1]};
        if (fbit) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  function automatic logic [7:0] exp_byte(input int slot, input int idx, input logic [31:0] crc);
    int n, len;
    n = exp_len[slot]; len = n + 6;
    if (idx == 0) return 8'(len);
    if (idx == 1) return 8'(len >> 8);
    if (idx < n + 2) return exp_dat[slot][idx - 2];
    if (idx < n + 6) return crc[8*(idx - n - 2) +: 8];
    return 8'h00;
  endfunction

  task automatic drain_one();
    logic [31:0] w, e, crc;
    int nw;
    string tag;
    crc = crc_ref(mh);
    nw = (exp_len[mh] + 6 + 3) / 4;
    for (int j = 0; j < nw; j++) begin
      reg_read(3'd3, w);
      for (int b = 0; b < 4; b++) e[8*b +: 8] = exp_byte(mh, 4*j + b, crc);
      tag = (j == 0) ? "R3 header" : (j == nw - 1) ? "R4 R5 tail" : "R6 body";
      check(w == e, tag, w, e);
    end
    mh = (mh + 1) % 64; mc--;
    reg_read(3'd4, w);
    check(w == 32'(mc), "R6 count after drain", w, 32'(mc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state
    check(rx_ready_o == 1'b1, "R11 ready after reset", 32'(rx_ready_o), 1);
    check(irq_o == 1'b0, "R11 irq after reset", 32'(irq_o), 0);
    reg_read(3'd0, v); check(v == 0, "R11 status reset", v, 0);
    reg_read(3'd1, v); check(v == 1, "R11 mask reset", v, 1);
    reg_read(3'd2, v); check(v == 0, "R11 ctrl reset", v, 0);
    reg_read(3'd4, v); check(v == 0, "R11 count reset", v, 0);

    // empty read
    reg_read(3'd3, v); check(v == 0, "R7 empty data read", v, 0);
    reg_read(3'd4, v); check(v == 0, "R7 count after empty read", v, 0);

    // disabled receive
    send_frame(10, 1'b0);
    reg_read(3'd4, v); check(v == 0, "R1 count while disabled", v, 0);
    reg_read(3'd0, v); check(v == 0, "R1 status while disabled", v, 0);

    reg_write(3'd2, 32'h1);
    reg_read(3'd2, v); check(v == 1, "R11 ctrl readback", v, 1);

    // one byte frame, status and irq
    send_frame(1, 1'b1);
    reg_read(3'd4, v); check(v == 1, "R6 count after store", v, 1);
    reg_read(3'd0, v); check(v == 1, "R9 status set", v, 1);
    check(irq_o == 1'b1, "R9 irq raised", 32'(irq_o), 1);
    drain_one();
    reg_write(3'd0, 32'h1);
    reg_read(3'd0, v); check(v == 0, "R9 status cleared", v, 0);
    check(irq_o == 1'b0, "R9 irq cleared", 32'(irq_o), 0);

    // masked interrupt
    reg_write(3'd1, 32'h0);
    send_frame(7, 1'b1);
    reg_read(3'd0, v); check(v == 1, "R9 status under mask", v, 1);
    check(irq_o == 1'b0, "R9 irq masked", 32'(irq_o), 0);
    reg_write(3'd1, 32'h1);
    check(irq_o == 1'b1, "R9 irq unmasked", 32'(irq_o), 1);
    reg_write(3'd0, 32'h1);
    drain_one();

    // directed lengths covering each pad amount and the limit
    send_frame(2, 1'b1); drain_one();
    send_frame(3, 1'b1); drain_one();
    send_frame(4, 1'b1); drain_one();
    send_frame(MAXF, 1'b1); drain_one();

    // oversize frame
    send_frame(MAXF + 1, 1'b0);
    reg_read(3'd4, v); check(v == 0, "R10 oversize dropped", v, 0);
    send_frame(MAXF + 6, 1'b0);
    reg_read(3'd4, v); check(v == 0, "R10 long frame dropped", v, 0);

    // random traffic
    for (int r = 0; r < 24; r++) begin
      int ns, nd;
      ns = 1 + int'($urandom % 3);
      for (int s = 0; s < ns; s++) if (mc < NSLOT) send_frame(1 + int'($urandom % MAXF), 1'b1);
      nd = int'($urandom % 4);
      for (int d = 0; d < nd; d++) if (mc > 0) drain_one();
    end
    while (mc > 0) drain_one();

    // fill to capacity, then one more
    for (int i = 0; i < NSLOT; i++) send_frame(1 + int'($urandom % MAXF), 1'b1);
    reg_read(3'd4, v); check(v == NSLOT, "R2 full count", v, NSLOT);
    check(rx_ready_o == 1'b1, "R2 ready while full", 32'(rx_ready_o), 1);
    send_frame(20, 1'b0);
    reg_read(3'd4, v); check(v == NSLOT, "R2 drop when full", v, NSLOT);
    while (mc > 0) drain_one();
    reg_read(3'd3, v); check(v == 0, "R7 read after drain", v, 0);

    // flush in the middle of a packet
    send_frame(30, 1'b1); send_frame(12, 1'b1); send_frame(5, 1'b1);
    reg_read(3'd3, v);
    reg_write(3'd2, 32'h3);
    reg_read(3'd4, v); check(v == 0, "R8 count after flush", v, 0);
    reg_read(3'd2, v); check(v == 1, "R8 flush bit self clears", v, 1);
    reg_read(3'd3, v); check(v == 0, "R8 data read after flush", v, 0);
    mh = (mh + mc) % 64; mc = 0;
    send_frame(5, 1'b1);
    drain_one();

    done = 1'b1;
    summary();
  end

endmodule